// File: doc/BRIEF.md
# Card Access Strobe Sequencer

This block carries out a single PC-card bus cycle once a window decoder has matched an address. The decoder hands over the card address, the target space (common memory, attribute memory or I/O), the direction, the write data and three timing fields counted in bus clocks. The sequencer then drives the card through three phases. First it presents the address with chip-select for the setup time. Next it pulses one read or write strobe for the strobe length. Last it keeps address and chip-select steady for the hold time before it reports completion.

The space decides which strobe is used. Memory spaces use output-enable and write-enable, and attribute space also drives a separate space-select line. I/O space uses the dedicated I/O read and I/O write strobes. A bus monitor counts every cycle of the access. An access that would run past the monitor limit is cut off, all strobes are released and an error pulse is raised in place of completion.

Top module: `card_strobe_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `card_cs_n`, `card_reg_n` and all four strobes are 1, `card_dout_en` is 0, and `rsp_done` and `rsp_err` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in idle. A `req_valid` seen while busy changes nothing in the access in progress.
- R3: An access runs a setup phase of max(S,1) cycles, then a strobe phase of max(L,1) cycles, then a hold phase of max(H,1) cycles. S is `req_setup` (4 bits), L is `req_strobe` (5 bits) and H is `req_hold` (4 bits). `card_cs_n` is 0 in all three phases, and a strobe is active only in the strobe phase.
- R4: `req_space` encodes space as 00 common, 01 attribute, 1x I/O, and `req_write` is 1 for a write. In the strobe phase exactly one strobe goes low: `card_oe_n` for a memory read, `card_we_n` for a memory write, `card_iord_n` for an I/O read, `card_iowr_n` for an I/O write.
- R5: `card_reg_n` is 0 in every phase of an attribute-space access and 1 otherwise.
- R6: For a read, the value on `card_din` in the last strobe cycle appears on `rsp_rdata` when `rsp_done` is pulsed.
- R7: For a write, `card_dout_en` is 1 and `card_dout` carries the write data in every phase of the access. For a read, `card_dout_en` stays 0.
- R8: `rsp_done` is a one-cycle pulse in the cycle after the last hold cycle. `req_ready` is 0 in that cycle and 1 in the next.
- R9: Access cycles are counted from the first setup cycle. An access of up to 60 cycles completes normally. A longer one ends after its 60th cycle: the next cycle carries a one-cycle `rsp_err` pulse with no `rsp_done`, all strobes and chip-select are released, and the sequencer then returns to idle.
- R10: `card_addr` holds the address taken with the request throughout the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Window hit request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 26 | Card address |
| req_space | input | 2 | 00 common, 01 attribute, 1x I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_setup | input | 4 | Setup cycles |
| req_strobe | input | 5 | Strobe cycles |
| req_hold | input | 4 | Hold cycles |
| req_wdata | input | 16 | Write data |
| card_addr | output | 26 | Address to card |
| card_cs_n | output | 1 | Card chip-select, active low |
| card_reg_n | output | 1 | Attribute space select, active low |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_we_n | output | 1 | Memory write strobe, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_dout | output | 16 | Write data to card |
| card_dout_en | output | 1 | Write data drive enable |
| card_din | input | 16 | Read data from card |
| rsp_done | output | 1 | Access complete pulse |
| rsp_err | output | 1 | Bus monitor abort pulse |
| rsp_rdata | output | 16 | Captured read data |

## Verification
The bench sets zero-valued phase fields to check that each phase still takes one cycle. A design that skipped such a phase would raise the strobe in the same cycle as the first setup cycle. Card read data changes every cycle, so a capture one cycle early or late returns the wrong word. The bench tests the monitor limit on both sides: a 60-cycle access must finish, and a 61-cycle access must abort with an error. An off-by-one limit would abort the first or let the second complete. It also holds `req_valid` high with other values while an access runs, which exposes a design that accepts or latches a request while busy.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_FINISH = 3'd4
  } cseq_state_e;

  localparam logic [1:0] SPACE_COMMON = 2'b00;
  localparam logic [1:0] SPACE_ATTR   = 2'b01;

  function automatic logic space_is_io(input logic [1:0] sp);
    return sp[1];
  endfunction
endpackage

// File: rtl/cseq_phase_ctrl.sv
module cseq_phase_ctrl
  import cseq_pkg::*;
#(
  parameter int SW = 4,
  parameter int LW = 5,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] setup_len,
  input  logic [LW-1:0] strobe_len,
  input  logic [HW-1:0] hold_len,
  input  logic          abort,
  output cseq_state_e   state,
  output logic          phase_last,
  output logic          err_flag
);
  localparam int CW0 = (SW > LW) ? SW : LW;
  localparam int CW  = (CW0 > HW) ? CW0 : HW;

  logic [CW-1:0] pcnt_q, pcnt_d;
  cseq_state_e   state_d;
  logic          err_d;
  logic          run_en;

  logic [CW-1:0] ld_setup, ld_strobe, ld_hold;
  assign ld_setup  = (setup_len  == '0) ? '0 : (CW'(setup_len)  - CW'(1));
  assign ld_strobe = (strobe_len == '0) ? '0 : (CW'(strobe_len) - CW'(1));
  assign ld_hold   = (hold_len   == '0) ? '0 : (CW'(hold_len)   - CW'(1));

  assign phase_last = (pcnt_q == '0);
  assign run_en     = (state != ST_IDLE) || start;

  always_comb begin
    state_d = state;
    pcnt_d  = pcnt_q;
    err_d   = err_flag;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          pcnt_d  = ld_setup;
          err_d   = 1'b0;
        end
      end
      ST_SETUP: begin
        if (abort) begin
          state_d = ST_FINISH;
          err_d   = 1'b1;
        end else if (phase_last) begin
          state_d = ST_STROBE;
          pcnt_d  = ld_strobe;
        end else begin
          pcnt_d = pcnt_q - CW'(1);
        end
      end
      ST_STROBE: begin
        if (abort) begin
          state_d = ST_FINISH;
          err_d   = 1'b1;
        end else if (phase_last) begin
          state_d = ST_HOLD;
          pcnt_d  = ld_hold;
        end else begin
          pcnt_d = pcnt_q - CW'(1);
        end
      end
      ST_HOLD: begin
        if (phase_last) begin
          state_d = ST_FINISH;
        end else if (abort) begin
          state_d = ST_FINISH;
          err_d   = 1'b1;
        end else begin
          pcnt_d = pcnt_q - CW'(1);
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pcnt_q   <= '0;
      err_flag <= 1'b0;
    end else if (run_en) begin
      state    <= state_d;
      pcnt_q   <= pcnt_d;
      err_flag <= err_d;
    end
  end

  p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start) |=> (state == ST_SETUP));
  p_strobe_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STROBE) |-> $past(state == ST_SETUP || state == ST_STROBE));
  p_finish_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FINISH) |=> (state == ST_IDLE));
endmodule

// File: rtl/cseq_bus_monitor.sv
module cseq_bus_monitor #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] tcnt_q, tcnt_d, tcur;

  assign tcur   = tcnt_q + TW'(1);
  assign expire = active && (tcur == TW'(LIMIT));
  assign tcnt_d = active ? tcur : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end

  p_window_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (tcnt_q < TW'(LIMIT)));
endmodule

// File: rtl/cseq_strobe_decode.sv
module cseq_strobe_decode
  import cseq_pkg::*;
(
  input  cseq_state_e state,
  input  logic [1:0]  space,
  input  logic        write,
  output logic        cs_n,
  output logic        reg_n,
  output logic        oe_n,
  output logic        we_n,
  output logic        iord_n,
  output logic        iowr_n,
  output logic        dout_en
);
  logic active, pulse, io;

  always_comb begin
    active  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    pulse   = (state == ST_STROBE);
    io      = space_is_io(space);
    cs_n    = !active;
    reg_n   = !(active && (space == SPACE_ATTR));
    oe_n    = !(pulse && !io && !write);
    we_n    = !(pulse && !io &&  write);
    iord_n  = !(pulse &&  io && !write);
    iowr_n  = !(pulse &&  io &&  write);
    dout_en = active && write;
  end
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
  import cseq_pkg::*;
#(
  parameter int AW    = 26,
  parameter int DW    = 16,
  parameter int SW    = 4,
  parameter int LW    = 5,
  parameter int HW    = 4,
  parameter int LIMIT = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_space,
  input  logic          req_write,
  input  logic [SW-1:0] req_setup,
  input  logic [LW-1:0] req_strobe,
  input  logic [HW-1:0] req_hold,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] card_addr,
  output logic          card_cs_n,
  output logic          card_reg_n,
  output logic          card_oe_n,
  output logic          card_we_n,
  output logic          card_iord_n,
  output logic          card_iowr_n,
  output logic [DW-1:0] card_dout,
  output logic          card_dout_en,
  input  logic [DW-1:0] card_din,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  cseq_state_e   state;
  logic          phase_last, err_flag, expire, accept, active, cap_en;
  logic [1:0]    space_q;
  logic          write_q;
  logic [LW-1:0] strobe_q;
  logic [HW-1:0] hold_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign active    = !card_cs_n;
  assign cap_en    = (state == ST_STROBE) && phase_last && !write_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      card_addr <= '0;
      space_q   <= SPACE_COMMON;
      write_q   <= 1'b0;
      strobe_q  <= '0;
      hold_q    <= '0;
      card_dout <= '0;
    end else if (accept) begin
      card_addr <= req_addr;
      space_q   <= req_space;
      write_q   <= req_write;
      strobe_q  <= req_strobe;
      hold_q    <= req_hold;
      card_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    rsp_rdata <= '0;
    else if (cap_en) rsp_rdata <= card_din;
  end

  cseq_phase_ctrl #(.SW(SW), .LW(LW), .HW(HW)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (accept),
    .setup_len  (req_setup),
    .strobe_len (strobe_q),
    .hold_len   (hold_q),
    .abort      (expire),
    .state      (state),
    .phase_last (phase_last),
    .err_flag   (err_flag)
  );

  cseq_bus_monitor #(.LIMIT(LIMIT)) u_mon (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .active (active),
    .expire (expire)
  );

  cseq_strobe_decode u_dec (
    .state   (state),
    .space   (space_q),
    .write   (write_q),
    .cs_n    (card_cs_n),
    .reg_n   (card_reg_n),
    .oe_n    (card_oe_n),
    .we_n    (card_we_n),
    .iord_n  (card_iord_n),
    .iowr_n  (card_iowr_n),
    .dout_en (card_dout_en)
  );

  assign rsp_done = (state == ST_FINISH) && !err_flag;
  assign rsp_err  = (state == ST_FINISH) &&  err_flag;

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    $countones({~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n}) <= 1);
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n) |-> !card_cs_n);
  p_done_then_ready_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_done |=> req_ready);
  p_err_released_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_err |-> (card_cs_n && card_oe_n && card_we_n && card_iord_n && card_iowr_n));
  p_accept_setup_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && req_ready) |=> (!card_cs_n && card_oe_n && card_we_n && !req_ready));
  p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!card_cs_n && $past(!card_cs_n)) |-> $stable(card_addr));
  p_dout_in_access_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    card_dout_en |-> !card_cs_n);
endmodule

// File: tb/card_strobe_seq_test.sv
module card_strobe_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [25:0] req_addr;
  logic [1:0]  req_space;
  logic        req_write;
  logic [3:0]  req_setup;
  logic [4:0]  req_strobe;
  logic [3:0]  req_hold;
  logic [15:0] req_wdata;
  logic [25:0] card_addr;
  logic        card_cs_n, card_reg_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n;
  logic [15:0] card_dout;
  logic        card_dout_en;
  logic [15:0] card_din;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  card_strobe_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_space(req_space), .req_write(req_write),
    .req_setup(req_setup), .req_strobe(req_strobe), .req_hold(req_hold),
    .req_wdata(req_wdata), .card_addr(card_addr), .card_cs_n(card_cs_n),
    .card_reg_n(card_reg_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
    .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n), .card_dout(card_dout),
    .card_dout_en(card_dout_en), .card_din(card_din), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input int s, input int l, input int h, input int sp, input bit wr,
                     input logic [25:0] a, input logic [15:0] wd, input logic [15:0] pat,
                     input bit noisy);
    int es, el, eh, tot, act, ph;
    bit io;
    logic [3:0] exp_str, got_str;
    es = (s == 0) ? 1 : s;
    el = (l == 0) ? 1 : l;
    eh = (h == 0) ? 1 : h;
    tot = es + el + eh;
    act = (tot > 60) ? 60 : tot;
    io = (sp >= 2);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_space = sp[1:0]; req_write = wr;
    req_setup = s[3:0]; req_strobe = l[4:0]; req_hold = h[3:0]; req_wdata = wd;
    for (int k = 1; k <= act; k++) begin
      @(negedge clk);
      req_valid = noisy;
      if (noisy) begin
        req_addr = ~a; req_space = ~sp[1:0]; req_write = ~wr;
        req_setup = 4'd0; req_strobe = 5'd0; req_hold = 4'd0; req_wdata = ~wd;
      end
      card_din = pat ^ 16'(k);
      ph = (k <= es) ? 1 : ((k <= es + el) ? 2 : 3);
      exp_str = {!(ph == 2 && !io && !wr), !(ph == 2 && !io && wr),
                 !(ph == 2 && io && !wr), !(ph == 2 && io && wr)};
      got_str = {card_oe_n, card_we_n, card_iord_n, card_iowr_n};
      chk(card_cs_n == 1'b0, "R3", "cs_n in access", card_cs_n, 0);
      chk(got_str == exp_str, (ph == 2) ? "R4" : "R3", "strobes {oe,we,iord,iowr}", got_str, exp_str);
      chk(card_reg_n == !(sp == 1), "R5", "reg_n", card_reg_n, !(sp == 1));
      chk(card_dout_en == wr, "R7", "dout_en", card_dout_en, wr);
      if (wr) chk(card_dout == wd, "R7", "dout", card_dout, wd);
      chk(card_addr == a, "R10", "addr", card_addr, a);
      chk(req_ready == 1'b0 && rsp_done == 1'b0 && rsp_err == 1'b0, "R2",
          "ready/done/err busy", {req_ready, rsp_done, rsp_err}, 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (tot <= 60) begin
      chk(rsp_done == 1'b1 && rsp_err == 1'b0, "R8", "done/err at end", {rsp_done, rsp_err}, 2'b10);
      if (!wr) chk(rsp_rdata == (pat ^ 16'(es + el)), "R6", "rdata", rsp_rdata, pat ^ 16'(es + el));
    end else begin
      chk(rsp_err == 1'b1 && rsp_done == 1'b0, "R9", "done/err on abort", {rsp_done, rsp_err}, 2'b01);
    end
    chk({card_cs_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n} == 5'h1f, (tot > 60) ? "R9" : "R8",
        "released at end", {card_cs_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n}, 5'h1f);
    chk(req_ready == 1'b0, "R8", "ready in end cycle", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_done == 1'b0 && rsp_err == 1'b0, "R8", "idle after end",
        {req_ready, rsp_done, rsp_err}, 3'b100);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_space = '0; req_write = 1'b0;
    req_setup = '0; req_strobe = '0; req_hold = '0; req_wdata = '0; card_din = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && card_cs_n && card_reg_n && card_oe_n && card_we_n &&
        card_iord_n && card_iowr_n && !card_dout_en && !rsp_done && !rsp_err,
        "R1", "reset outputs", {req_ready, card_cs_n, rsp_done, rsp_err}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && card_cs_n && !rsp_done && !rsp_err, "R1", "after reset release",
        {req_ready, card_cs_n, rsp_done, rsp_err}, 4'b1100);
    run(2, 3, 1, 0, 1'b0, 26'h0123456, 16'h0000, 16'hA500, 1'b0);
    run(0, 0, 0, 0, 1'b1, 26'h3ffffff, 16'hBEEF, 16'h0000, 1'b0);
    run(1, 5, 2, 1, 1'b0, 26'h0000200, 16'h0000, 16'h5A00, 1'b0);
    run(3, 2, 4, 2, 1'b0, 26'h00000f8, 16'h0000, 16'hC300, 1'b1);
    run(0, 7, 0, 3, 1'b1, 26'h0000040, 16'h1234, 16'h0000, 1'b1);
    run(15, 31, 14, 1, 1'b1, 26'h1555555, 16'h8001, 16'h0000, 1'b0);
    run(15, 31, 14, 0, 1'b0, 26'h0aaaaaa, 16'h0000, 16'h7700, 1'b0);
    run(15, 31, 15, 0, 1'b0, 26'h2000000, 16'h0000, 16'h3300, 1'b0);
    run(4, 1, 0, 2, 1'b1, 26'h0000010, 16'h00FF, 16'h0000, 1'b0);
    run(0, 1, 3, 0, 1'b0, 26'h0000001, 16'h0000, 16'hF000, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule